// File: doc/BRIEF.md
# Pseudo-SRAM configuration register loader

This block sits at the host-facing edge of a pseudo-static memory device. It holds the two configuration words that steer the device: a bus configuration word and a refresh configuration word. The host has no data path into these words. Instead, it runs an ordinary write access with the control-register select input driven high, and the word is taken from the 22 address inputs. The same access with the select input low is an ordinary array write. In that case the block forwards a one-cycle write strobe with the byte enables to the array logic.

All strobe inputs are sampled on the block clock. A capture occurs on the first rising edge among address-valid, chip-enable and write-enable, all of which are active low. The captured value is the address, select bit and write-enable state held in the cycle just before that edge. The capture logic then stays disarmed until chip-enable is seen high again, so each access captures once. Address bit 19 chooses the target word. A load is accepted only while the device reports standby. A load attempted outside standby is discarded and sets a sticky error flag. Both words are exported continuously for the refresh and bus logic. The page-mode enable bit of the refresh word is also exported as a separate output.

Top module: `psram_cfg_loader`

## Requirements
- R1: A write access with `cre` high at capture updates a configuration word and gives no `array_wr` pulse. A write access with `cre` low gives one `array_wr` pulse and leaves both words unchanged.
- R2: The value loaded equals `addr[21:0]` as sampled in the cycle before the capturing edge.
- R3: Capture happens on the first rising edge among `adv_n`, `ce_n` and `we_n` while `ce_n` was low. Later rising edges in the same access cause no load and no pulse, even if the address has changed.
- R4: Address bit 19 set at capture loads `bus_cfg`. Address bit 19 clear loads `ref_cfg`. The word not selected keeps its value.
- R5: `ub_n` and `lb_n` have no effect on a configuration load. On an array write, `array_be` is {~ub_n, ~lb_n} as sampled before capture.
- R6: While reset is held, and after it, `bus_cfg` = 22'h09D11F, `ref_cfg` = 22'h000010, and `page_mode`, `array_wr` and `cfg_err` are all 0.
- R7: A configuration load is accepted only if `standby` is high at the capturing clock edge. Otherwise the word is left unchanged and `cfg_err` is set, and it stays set until reset.
- R8: `page_mode` always equals bit 7 of `ref_cfg`.
- R9: After a capture, the capture logic re-arms only once `ce_n` has been sampled high, so each access captures at most once.
- R10: An access with `we_n` high in the cycle before the first rising edge is a read. It loads nothing and gives no `array_wr` pulse.
- R11: Loaded words, `cfg_err` and the `array_wr` pulse appear at the clock edge that first samples the capturing rise. The pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address valid, active low |
| cre | input | 1 | High selects a configuration load instead of an array write |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr | input | 22 | Address bus; carries the value for a configuration load |
| standby | input | 1 | High while the device is idle and may accept configuration loads |
| bus_cfg | output | 22 | Bus configuration word |
| ref_cfg | output | 22 | Refresh configuration word |
| page_mode | output | 1 | Page-mode enable taken from the refresh word |
| array_wr | output | 1 | One-cycle array write strobe |
| array_be | output | 2 | Byte enables of the array write, active high, upper in bit 1 |
| cfg_err | output | 1 | Sticky flag: a configuration load was refused outside standby |

## Verification
Every result of a capture is due at the first clock edge that samples the capturing rise. The bench drives each edge on a falling clock edge and checks the words, the flag and the pulse on the next falling edge. One cycle later it checks that the pulse has dropped and that the trailing rises, driven with a changed address, left everything unchanged. The sweep covers every choice of first strobe, select bit, byte-enable pair and mode across several address patterns, plus read accesses. Loads refused outside standby come last, because the error flag they set is sticky.

// File: rtl/psram_cfg_loader.sv
module psram_cfg_loader #(
  parameter int ADDR_W   = 22,
  parameter int SEL_BIT  = 19,
  parameter int PAGE_BIT = 7,
  parameter logic [ADDR_W-1:0] BUS_DEF = 'h09D11F,
  parameter logic [ADDR_W-1:0] REF_DEF = 'h000010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              adv_n,
  input  logic              cre,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              standby,
  output logic [ADDR_W-1:0] bus_cfg,
  output logic [ADDR_W-1:0] ref_cfg,
  output logic              page_mode,
  output logic              array_wr,
  output logic [1:0]        array_be,
  output logic              cfg_err
);

  logic              p_ce, p_we, p_adv, p_cre, p_ub, p_lb;
  logic [ADDR_W-1:0] p_addr;
  logic              armed;

  wire rise_any = (~p_adv & adv_n) | (~p_ce & ce_n) | (~p_we & we_n);
  wire capture  = armed & rise_any & ~p_ce & ~p_we;
  wire cfg_req  = capture & p_cre;
  wire cfg_ok   = cfg_req & standby;
  wire to_bus   = p_addr[SEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ce   <= 1'b1;
      p_we   <= 1'b1;
      p_adv  <= 1'b1;
      p_cre  <= 1'b0;
      p_ub   <= 1'b1;
      p_lb   <= 1'b1;
      p_addr <= '0;
    end else begin
      p_ce   <= ce_n;
      p_we   <= we_n;
      p_adv  <= adv_n;
      p_cre  <= cre;
      p_ub   <= ub_n;
      p_lb   <= lb_n;
      p_addr <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b1;
    else if (capture) armed <= 1'b0;
    else if (ce_n)    armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_cfg <= BUS_DEF;
      ref_cfg <= REF_DEF;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_ok &  to_bus) bus_cfg <= p_addr;
      if (cfg_ok & ~to_bus) ref_cfg <= p_addr;
      if (cfg_req & ~standby) cfg_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      array_wr <= 1'b0;
      array_be <= 2'b00;
    end else begin
      array_wr <= capture & ~p_cre;
      if (capture & ~p_cre) array_be <= {~p_ub, ~p_lb};
    end
  end

  assign page_mode = ref_cfg[PAGE_BIT];

  a_r1_load_needs_cre: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_cfg) || !$stable(ref_cfg) |-> $past(p_cre) && !array_wr);
  a_r1_wr_needs_no_cre: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr |-> !$past(p_cre));
  a_r2_bus_value: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_cfg) |-> bus_cfg == $past(p_addr));
  a_r4_bus_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_cfg) |-> $past(p_addr[SEL_BIT]) && $stable(ref_cfg));
  a_r4_ref_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_cfg) |-> !$past(p_addr[SEL_BIT]) && $stable(bus_cfg));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  a_r7_standby_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_cfg) || !$stable(ref_cfg) |-> $past(standby));
  a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !armed);
  a_r11_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr |=> !array_wr);

endmodule

// File: tb/test_psram_cfg_loader.sv
module test_psram_cfg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, adv_n = 1'b1, cre = 1'b0;
  logic ub_n = 1'b1, lb_n = 1'b1, standby = 1'b1;
  logic [21:0] addr = '0;
  logic [21:0] bus_cfg, ref_cfg;
  logic page_mode, array_wr, cfg_err;
  logic [1:0] array_be;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [21:0] e_bus, e_ref;
  logic e_err;

  always #2 clk = ~clk;

  psram_cfg_loader i_psram_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .adv_n(adv_n),
    .cre(cre), .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .standby(standby),
    .bus_cfg(bus_cfg), .ref_cfg(ref_cfg), .page_mode(page_mode),
    .array_wr(array_wr), .array_be(array_be), .cfg_err(cfg_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " bus_cfg"}, {10'd0, bus_cfg}, {10'd0, e_bus});
    chk({req, " ref_cfg"}, {10'd0, ref_cfg}, {10'd0, e_ref});
    chk({req, " R8 page_mode"}, {31'd0, page_mode}, {31'd0, e_ref[7]});
    chk({req, " cfg_err"}, {31'd0, cfg_err}, {31'd0, e_err});
  endtask

  // first: 0 = adv_n, 1 = we_n, 2 = ce_n rises first
  task automatic access(input int first, input bit wr, input bit c,
                        input logic [21:0] a, input logic [1:0] be_n, input bit sb);
    bit exp_wr;
    @(negedge clk);
    ce_n = 0; adv_n = 0; we_n = wr ? 0 : 1; cre = c; addr = a;
    {ub_n, lb_n} = be_n; standby = sb;
    @(negedge clk);
    case (first)
      0: adv_n = 1;
      1: we_n = 1;
      default: ce_n = 1;
    endcase
    @(negedge clk);
    exp_wr = 0;
    if (wr && c) begin
      if (!sb) e_err = 1;
      else if (a[19]) e_bus = a;
      else e_ref = a;
    end else if (wr) exp_wr = 1;
    chk_state(wr ? (c ? "R1 R2 R4 R5 R7 R11 load" : "R1 array write") : "R10 read");
    chk("R1 R10 R11 array_wr", {31'd0, array_wr}, {31'd0, exp_wr});
    if (exp_wr) chk("R5 array_be", {30'd0, array_be}, {30'd0, ~be_n});
    addr = ~a; adv_n = 1; we_n = 1; ce_n = 1;
    @(negedge clk);
    chk("R3 R11 pulse ends", {31'd0, array_wr}, 32'd0);
    chk_state("R3 R9 later rises ignored");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    e_bus = 22'h09D11F; e_ref = 22'h000010; e_err = 0;
    repeat (2) @(negedge clk);
    chk_state("R6 reset");
    chk("R6 array_wr", {31'd0, array_wr}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk_state("R6 after reset");
    for (int k = 0; k < 3; k++)
      for (int f = 0; f < 3; f++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 2; c++)
            for (int b = 0; b < 4; b++) begin
              logic [21:0] a;
              a = 22'(k * 22'h1A5A5 + b * 22'h00091 + 22'h3C0F);
              a[19] = s[0];
              access(f, 1'b1, c[0], a, b[1:0], 1'b1);
            end
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 2; s++)
        access(f, 1'b0, 1'b1, {2'b00, s[0], 19'h5A5A5}, 2'b00, 1'b1);
    for (int f = 0; f < 3; f++) begin
      access(f, 1'b1, 1'b0, 22'h2AAAAA, 2'b10, 1'b0);
      access(f, 1'b1, 1'b1, 22'h3FFFFF, 2'b00, 1'b0);
      access(f, 1'b1, 1'b1, 22'h000000, 2'b11, 1'b0);
    end
    access(0, 1'b1, 1'b1, 22'h080F0F, 2'b00, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule